// File: doc/BRIEF.md
# Chopped-Sample Averaging Controller

This block follows a chopping converter and cancels the residual offset that chopping leaves on alternate samples. Each accepted raw sample is averaged with the one before it, and the mean is presented with a one-cycle valid strobe. Because the mean needs two samples from the same configuration, any restart leaves the pairing register empty. A restart is an explicit resynchronise pulse, such as a channel switch, or a write of the rate word. The first sample after a restart then yields nothing, and settling takes two conversion periods.

The block also paces the converter. An internal timer issues a one-cycle sample-request tick every `rate * TICKS_PER_SF` clock cycles. The rate word sets the period linearly, holds a legal range of 13 to 255, and comes out of reset at 69. A step on the analog input that arrives without a restart is not treated specially. Outputs keep flowing, the first mean after the step blends old and new data, and the next one is fully settled.

Top module: `chop_avg_ctrl`

## Requirements
- R1: After reset, `avg_o` is 0, `avg_vld_o` is 0, and the rate word holds 69, so ticks are 69*TICKS_PER_SF cycles apart.
- R2: Each output is floor((previous + current) / 2). Both samples are signed two's complement of SAMPLE_W bits, the sum is formed at SAMPLE_W+1 bits, and the shift rounds toward negative infinity.
- R3: `avg_vld_o` is high for exactly one cycle, the cycle after an accepted sample strobe. `avg_o` does not change while `avg_vld_o` is low.
- R4: After reset or a restart, the first accepted sample produces no output and the second produces the first valid mean.
- R5: A `resync_i` pulse in the same cycle as `smp_vld_i` discards that sample, and the following sample is again treated as a first sample.
- R6: A write on the configuration port acts as a restart: no mean pairs a sample from before the write with one from after it.
- R7: Written rate values below 13 are stored as 13, values above 255 are stored as 255, and values in between are stored unchanged.
- R8: `req_tick_o` is a single-cycle pulse, and consecutive pulses are rate*TICKS_PER_SF cycles apart.
- R9: A configuration write restarts the timer. Counting the write cycle as cycle 0, the next tick falls in cycle rate*TICKS_PER_SF, and no tick is issued in the write cycle itself.
- R10: An input step with no restart does not stop the outputs. For samples A, A, B, B the outputs are A, floor((A+B)/2), B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_i | input | SAMPLE_W | Signed raw sample from the converter |
| smp_vld_i | input | 1 | Raw sample strobe |
| resync_i | input | 1 | Restart pulse (channel switch or reprogramming) |
| cfg_wr_i | input | 1 | Rate word write enable |
| cfg_wdata_i | input | WR_W | Rate word write data, unsigned, clamped on write |
| avg_o | output | SAMPLE_W | Signed two-sample mean |
| avg_vld_o | output | 1 | One-cycle strobe marking a new mean |
| req_tick_o | output | 1 | One-cycle sample-request pulse from the conversion timer |

## Verification
On every cycle, the assertions check the following. The stored rate word stays inside its legal range. The tick never lasts two cycles. A valid strobe only ever follows a sample strobe by one cycle. The mean holds between strobes. A restart, whether a pulse or a write, is never followed by a strobe, and a sample taken with the pairing register empty produces none.

The bench scenarios cover the rest. They check the arithmetic value of each mean over a sweep of corner-value pairs, including rounding of odd negative sums. They check the clamping of written values, measured through tick spacing, the reload distance after a write, and the mixed-then-settled sequence after an unannounced step.

// File: rtl/chop_avg_pkg.sv
package chop_avg_pkg;
  // Occupancy of the pairing register in the averager
  typedef enum logic {
    PAIR_EMPTY  = 1'b0,
    PAIR_PRIMED = 1'b1
  } pair_state_e;
endpackage

// File: rtl/chop_rate_reg.sv
module chop_rate_reg #(
  parameter int SF_W   = 8,
  parameter int WR_W   = 16,
  parameter int SF_MIN = 13,
  parameter int SF_MAX = 255,
  parameter int SF_RST = 69
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic [SF_W-1:0] rate_o
);
  logic [SF_W-1:0] rate_q, rate_d, clamp_c;

  always_comb begin
    if (wr_data_i < WR_W'(SF_MIN))      clamp_c = SF_W'(SF_MIN);
    else if (wr_data_i > WR_W'(SF_MAX)) clamp_c = SF_W'(SF_MAX);
    else                                clamp_c = wr_data_i[SF_W-1:0];
  end

  always_comb begin
    rate_d = rate_q;
    if (wr_en_i) rate_d = clamp_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= SF_W'(SF_RST);
    else        rate_q <= rate_d;
  end

  assign rate_o = rate_q;

  // R7
  rate_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q >= SF_W'(SF_MIN)) && (rate_q <= SF_W'(SF_MAX)));
endmodule

// File: rtl/chop_conv_timer.sv
module chop_conv_timer #(
  parameter int SF_W         = 8,
  parameter int TICKS_PER_SF = 4,
  parameter int CNT_W        = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SF_W-1:0] rate_i,
  input  logic            reload_i,
  output logic            tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last_c;
  logic             at_end_c;

  assign last_c   = CNT_W'(rate_i) * CNT_W'(TICKS_PER_SF) - CNT_W'(1);
  assign at_end_c = (cnt_q == last_c);

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    if (reload_i || at_end_c) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = at_end_c && !reload_i;

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R9
  reload_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == '0));
endmodule

// File: rtl/chop_pair_avg.sv
module chop_pair_avg
  import chop_avg_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_i,
  input  logic          smp_vld_i,
  input  logic          sync_i,
  output logic [DW-1:0] avg_o,
  output logic          avg_vld_o
);
  pair_state_e   st_q, st_d;
  logic [DW-1:0] prev_q, prev_d;
  logic [DW-1:0] avg_q, avg_d;
  logic          vld_q, vld_d;
  logic [DW:0]   sum_c;
  logic          take_c;

  // sign-extended sum at DW+1 bits, then floor shift by one
  assign sum_c  = {prev_q[DW-1], prev_q} + {smp_i[DW-1], smp_i};
  assign take_c = smp_vld_i && !sync_i;

  always_comb begin
    st_d   = st_q;
    prev_d = prev_q;
    avg_d  = avg_q;
    vld_d  = 1'b0;
    if (sync_i) begin
      st_d = PAIR_EMPTY;
    end else if (take_c) begin
      prev_d = smp_i;
      st_d   = PAIR_PRIMED;
      if (st_q == PAIR_PRIMED) begin
        avg_d = sum_c[DW:1];
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PAIR_EMPTY;
      prev_q <= '0;
      avg_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      prev_q <= prev_d;
      avg_q  <= avg_d;
      vld_q  <= vld_d;
    end
  end

  assign avg_o     = avg_q;
  assign avg_vld_o = vld_q;

  // R3
  vld_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_vld_o |-> $past(smp_vld_i && !sync_i));
  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_vld_o |-> $stable(avg_o));
  // R5
  sync_blocks_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !avg_vld_o);
  // R4
  first_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && st_q == PAIR_EMPTY) |=> !avg_vld_o);
endmodule

// File: rtl/chop_avg_ctrl.sv
module chop_avg_ctrl #(
  parameter int SAMPLE_W     = 24,
  parameter int SF_W         = 8,
  parameter int WR_W         = 16,
  parameter int SF_MIN       = 13,
  parameter int SF_MAX       = 255,
  parameter int SF_RST       = 69,
  parameter int TICKS_PER_SF = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                smp_vld_i,
  input  logic                resync_i,
  input  logic                cfg_wr_i,
  input  logic [WR_W-1:0]     cfg_wdata_i,
  output logic [SAMPLE_W-1:0] avg_o,
  output logic                avg_vld_o,
  output logic                req_tick_o
);
  localparam int CNT_W = $clog2(SF_MAX * TICKS_PER_SF + 1);

  logic            rst_meta_q, rst_sync_q;
  logic [SF_W-1:0] rate_w;
  logic            sync_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign sync_w = resync_i || cfg_wr_i;

  chop_rate_reg #(
    .SF_W(SF_W), .WR_W(WR_W), .SF_MIN(SF_MIN), .SF_MAX(SF_MAX), .SF_RST(SF_RST)
  ) u_rate (
    .clk(clk), .rst_n(rst_sync_q), .wr_en_i(cfg_wr_i),
    .wr_data_i(cfg_wdata_i), .rate_o(rate_w)
  );

  chop_conv_timer #(
    .SF_W(SF_W), .TICKS_PER_SF(TICKS_PER_SF), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .rate_i(rate_w),
    .reload_i(cfg_wr_i), .tick_o(req_tick_o)
  );

  chop_pair_avg #(
    .DW(SAMPLE_W)
  ) u_avg (
    .clk(clk), .rst_n(rst_sync_q), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .sync_i(sync_w), .avg_o(avg_o), .avg_vld_o(avg_vld_o)
  );

  // R6
  write_restarts_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cfg_wr_i |=> !avg_vld_o);
endmodule

// File: tb/test_chop_avg_ctrl.sv
`timescale 1ns/1ps
module test_chop_avg_ctrl;
  localparam int TPS = 2;
  localparam int DW  = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] smp_i;
  logic          smp_vld_i, resync_i, cfg_wr_i;
  logic [15:0]   cfg_wdata_i;
  logic [DW-1:0] avg_o;
  logic          avg_vld_o, req_tick_o;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chop_avg_ctrl #(.TICKS_PER_SF(TPS)) i_chop_avg_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .resync_i(resync_i), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
    .avg_o(avg_o), .avg_vld_o(avg_vld_o), .req_tick_o(req_tick_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint mean(input longint a, input longint b);
    return (a + b) >>> 1;
  endfunction

  // present one sample; returns at the negedge where its result is visible
  task automatic send(input longint v, input bit rs);
    @(negedge clk);
    smp_i = DW'(v); smp_vld_i = 1'b1; resync_i = rs;
    @(negedge clk);
    smp_vld_i = 1'b0; resync_i = 1'b0;
  endtask

  task automatic expect_out(input bit vexp, input longint val, input string req);
    chk(avg_vld_o == vexp, req, longint'(avg_vld_o), longint'(vexp));
    if (vexp) begin
      chk(sx(avg_o) == val, req, sx(avg_o), val);
      @(negedge clk);
      chk(!avg_vld_o, "R3 strobe width", longint'(avg_vld_o), 0);
      chk(sx(avg_o) == val, "R3 held", sx(avg_o), val);
    end
  endtask

  task automatic pulse_resync();
    @(negedge clk); resync_i = 1'b1;
    @(negedge clk); resync_i = 1'b0;
  endtask

  task automatic write_cfg(input int v);
    @(negedge clk); cfg_wr_i = 1'b1; cfg_wdata_i = 16'(v);
    chk(!req_tick_o, "R9 no tick in write cycle", longint'(req_tick_o), 0);
    @(negedge clk); cfg_wr_i = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!req_tick_o && n < 3000);
  endtask

  task automatic period_check(input int wr, input int rate, input string req);
    int n;
    write_cfg(wr);
    wait_tick(n);
    chk(n == rate*TPS - 1, "R9 reload distance", n, rate*TPS - 1);
    @(negedge clk);
    chk(!req_tick_o, "R8 single pulse", longint'(req_tick_o), 0);
    wait_tick(n);
    chk(n == rate*TPS - 1, req, n + 1, rate*TPS);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    longint vals [8] = '{8388607, -8388608, -1, 0, 1, 3, -3, 12345};
    int n;
    rst_n = 1'b0; smp_i = '0; smp_vld_i = 1'b0; resync_i = 1'b0;
    cfg_wr_i = 1'b0; cfg_wdata_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(avg_o == '0, "R1 reset data", sx(avg_o), 0);
    chk(!avg_vld_o, "R1 reset strobe", longint'(avg_vld_o), 0);
    wait_tick(n);
    wait_tick(n);
    chk(n == 69*TPS, "R1 R8 reset period", n, 69*TPS);

    // R2 R4: all ordered pairs of corner values, each after a restart
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        pulse_resync();
        send(vals[a], 1'b0);
        chk(!avg_vld_o, "R4 first sample silent", longint'(avg_vld_o), 0);
        send(vals[b], 1'b0);
        expect_out(1'b1, mean(vals[a], vals[b]), "R2 R4 pair mean");
      end
    end

    // R5: sample coincident with resync is dropped
    pulse_resync();
    send(100, 1'b0);
    send(200, 1'b0);
    expect_out(1'b1, 150, "R5 setup");
    send(999, 1'b1);
    chk(!avg_vld_o, "R5 coincident dropped", longint'(avg_vld_o), 0);
    send(-7, 1'b0);
    chk(!avg_vld_o, "R5 next is first", longint'(avg_vld_o), 0);
    send(-2, 1'b0);
    expect_out(1'b1, -5, "R5 pairing resumes");

    // R6: configuration write breaks the pair
    send(40, 1'b0);
    expect_out(1'b1, mean(-2, 40), "R6 before write");
    write_cfg(69);
    send(10, 1'b0);
    chk(!avg_vld_o, "R6 write restarts", longint'(avg_vld_o), 0);
    send(21, 1'b0);
    expect_out(1'b1, 15, "R6 after write");

    // R10: unannounced step A,A,B,B
    pulse_resync();
    send(-1000, 1'b0);
    chk(!avg_vld_o, "R10 first", longint'(avg_vld_o), 0);
    send(-1000, 1'b0);
    expect_out(1'b1, -1000, "R10 old level");
    send(3001, 1'b0);
    expect_out(1'b1, mean(-1000, 3001), "R10 mixed");
    send(3001, 1'b0);
    expect_out(1'b1, 3001, "R10 settled");

    // R7 R8 R9: clamping seen through tick spacing
    period_check(5, 13, "R7 low clamp period");
    period_check(1000, 255, "R7 high clamp period");
    period_check(0, 13, "R7 zero clamp period");
    period_check(13, 13, "R7 low edge period");
    period_check(255, 255, "R7 high edge period");
    period_check(100, 100, "R8 mid period");
    period_check(256, 255, "R7 just above period");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule